// File: doc/BRIEF.md
# Banked 40-bit DSP Register File

This block is the data register file of a DSP compute core. Each register is 40 bits wide and holds an untyped bit pattern. A compute unit may read a register as a 32-bit integer, as a 32-bit float or as a 40-bit extended-precision float, and nothing in the file changes between those views. There are 32 physical registers, arranged as two sets of 16. A registered set selector decides which set the 4-bit register indices address.

Five read ports and five write ports work in the same cycle, so several compute units can fetch operands and return results at once.

- **Reads** are combinational from the stored state.
- **Writes** land on the rising clock edge.
- **32-bit data** sits in the upper 32 bits of a register.
- **Banks:** the 16 visible registers form four banks of four. In quad-operand mode, read ports 0 to 3 are each tied to their own bank. This matches the restricted register fields of multi-operand instructions.

Top module: `rf_banked_top`

## Requirements
- R1: After reset every physical register in both sets holds zero and `activeSet` is 0.
- R2: A write with `wrWide` set stores all 40 bits of the port's data field. A read with `rdWide` set returns all 40 bits of the addressed register.
- R3: A write with `wrWide` clear stores data bits 31:0 into register bits 39:8 and clears register bits 7:0. Data bits 39:32 are ignored.
- R4: A read with `rdWide` clear returns register bits 39:8 on data bits 31:0 of its port, with bits 39:32 of the port at zero.
- R5: The physical register addressed is {activeSet, index}. A write in one set leaves the same index in the other set unchanged.
- R6: `activeSet` takes the value of `shadowSelReq` at each rising clock edge. Reads and writes before that edge still use the previous set.
- R7: All five read ports and all five write ports operate in the same cycle without affecting one another, apart from R8.
- R8: When several enabled write ports target the same register in one cycle, the lowest-numbered port's value is stored.
- R9: A read in the same cycle as a write to the same register returns the contents from before the write.
- R10: With `quadMode` set, read port k (k = 0..3) reads register 4k + index[1:0] and index bits 3:2 are ignored. Read port 4 keeps its full index.
- R11: A write port with `wrEn` clear changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| shadowSelReq | input | 1 | Set selector loaded at the next edge |
| quadMode | input | 1 | Ties read ports 0..3 to banks 0..3 |
| rdIdx | input | 20 | Read index, 4 bits per port, port k at bits 4k+3:4k |
| rdWide | input | 5 | Per read port: 1 = 40-bit read, 0 = 32-bit read |
| rdData | output | 200 | Read data, 40 bits per port, port k at bits 40k+39:40k |
| wrEn | input | 5 | Per write port enable |
| wrIdx | input | 20 | Write index, 4 bits per port |
| wrWide | input | 5 | Per write port: 1 = 40-bit write, 0 = 32-bit write |
| wrData | input | 200 | Write data, 40 bits per port |
| activeSet | output | 1 | Register set currently addressed |

## Verification
- **Read timing:** read data is due in the same cycle as the index, since the path is combinational from the registers. The bench samples it 1 ns after driving inputs at the falling edge.
- **Write timing:** a write becomes visible on reads one rising edge after it is presented.
- **Set switch timing:** the new set appears on `activeSet`, and on every read, after one rising edge.
- **Reference model:** the bench updates its own model right after each rising edge, from the inputs held across that edge. It then compares every read port and `activeSet` in the following cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DATA_W   = 40;
  localparam int RF_NARROW_W = 32;
  localparam int RF_VIS      = 16;
  localparam int RF_SETS     = 2;
  localparam int RF_RD       = 5;
  localparam int RF_WR       = 5;
  localparam int RF_BANK_SZ  = 4;

  localparam int RF_PAD_W   = RF_DATA_W - RF_NARROW_W;
  localparam int RF_IDX_W   = $clog2(RF_VIS);
  localparam int RF_SET_W   = $clog2(RF_SETS);
  localparam int RF_PHYS    = RF_VIS * RF_SETS;
  localparam int RF_PHYS_W  = $clog2(RF_PHYS);
  localparam int RF_WSEL_W  = $clog2(RF_WR);
  localparam int RF_SLOT_W  = $clog2(RF_BANK_SZ);
  localparam int RF_BANKS   = RF_VIS / RF_BANK_SZ;
  localparam int RF_BANK_W  = RF_IDX_W - RF_SLOT_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [RF_PHYS-1:0]                 regWe;
    logic [RF_PHYS-1:0]                 regWide;
    logic [RF_PHYS-1:0][RF_WSEL_W-1:0]  regSrc;
    logic [RF_RD-1:0][RF_PHYS_W-1:0]    rdPhys;
  } rf_strobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [RF_SET_W-1:0]         setReq,
  input  logic                        quadMode,
  input  logic [RF_RD*RF_IDX_W-1:0]   rdIdx,
  input  logic [RF_WR-1:0]            wrEn,
  input  logic [RF_WR*RF_IDX_W-1:0]   wrIdx,
  input  logic [RF_WR-1:0]            wrWide,
  output rf_strobe_t                  strobe,
  output logic [RF_SET_W-1:0]         activeSet
);
  logic [RF_SET_W-1:0] activeSetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeSetQ <= '0;
    else       activeSetQ <= setReq;
  end
  assign activeSet = activeSetQ;

  // write decode: scan from the highest port down so port 0 has the last word
  always_comb begin
    strobe.regWe   = '0;
    strobe.regWide = '0;
    strobe.regSrc  = '0;
    for (int p = 0; p < RF_PHYS; p++) begin
      for (int w = RF_WR - 1; w >= 0; w--) begin
        if (wrEn[w] && ({activeSetQ, wrIdx[w*RF_IDX_W +: RF_IDX_W]} == RF_PHYS_W'(p))) begin
          strobe.regWe[p]   = 1'b1;
          strobe.regWide[p] = wrWide[w];
          strobe.regSrc[p]  = RF_WSEL_W'(w);
        end
      end
    end
  end

  // read decode: ports below the bank count can be pinned to their bank
  for (genvar r = 0; r < RF_RD; r++) begin : g_rd
    logic [RF_IDX_W-1:0] rawIdx;
    assign rawIdx = rdIdx[r*RF_IDX_W +: RF_IDX_W];
    if (r < RF_BANKS) begin : g_quad
      logic [RF_IDX_W-1:0] effIdx;
      assign effIdx = quadMode ? {RF_BANK_W'(r), rawIdx[RF_SLOT_W-1:0]} : rawIdx;
      assign strobe.rdPhys[r] = {activeSetQ, effIdx};

      a_r10_quad_bank: assert property (@(posedge clk) disable iff (!rstN)
        quadMode |-> (strobe.rdPhys[r][RF_IDX_W-1:RF_SLOT_W] == RF_BANK_W'(r))
                  && (strobe.rdPhys[r][RF_SLOT_W-1:0] == rawIdx[RF_SLOT_W-1:0]));
    end else begin : g_plain
      assign strobe.rdPhys[r] = {activeSetQ, rawIdx};
    end
  end

  a_r6_set_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> activeSet == $past(setReq));

  a_r8_port0_wins: assert property (@(posedge clk) disable iff (!rstN)
    wrEn[0] |-> strobe.regWe[{activeSetQ, wrIdx[RF_IDX_W-1:0]}]
             && (strobe.regSrc[{activeSetQ, wrIdx[RF_IDX_W-1:0]}] == '0));
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  rf_strobe_t                  strobe,
  input  logic [RF_WR*RF_DATA_W-1:0]  wrData,
  input  logic [RF_RD-1:0]            rdWide,
  output logic [RF_RD*RF_DATA_W-1:0]  rdData
);
  logic [RF_PHYS-1:0][RF_DATA_W-1:0] regQ;
  logic [RF_PHYS-1:0][RF_DATA_W-1:0] nextWord;

  always_comb begin
    for (int p = 0; p < RF_PHYS; p++) begin
      logic [RF_DATA_W-1:0] src;
      src = wrData[int'(strobe.regSrc[p])*RF_DATA_W +: RF_DATA_W];
      nextWord[p] = strobe.regWide[p] ? src : {src[RF_NARROW_W-1:0], {RF_PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int p = 0; p < RF_PHYS; p++)
        if (strobe.regWe[p]) regQ[p] <= nextWord[p];
    end
  end

  for (genvar p = 0; p < RF_PHYS; p++) begin : g_chk
    a_r3_low_byte_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.regWe[p] && !strobe.regWide[p]) |=> regQ[p][RF_PAD_W-1:0] == '0);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.regWe[p] |=> $stable(regQ[p]));
  end

  for (genvar r = 0; r < RF_RD; r++) begin : g_rd
    logic [RF_DATA_W-1:0] word;
    assign word = regQ[strobe.rdPhys[r]];
    assign rdData[r*RF_DATA_W +: RF_DATA_W] =
      rdWide[r] ? word : {{RF_PAD_W{1'b0}}, word[RF_DATA_W-1:RF_PAD_W]};

    a_r4_narrow_pad: assert property (@(posedge clk) disable iff (!rstN)
      !rdWide[r] |-> rdData[r*RF_DATA_W + RF_NARROW_W +: RF_PAD_W] == '0);
  end
endmodule

// File: rtl/rf_banked_top.sv
module rf_banked_top
  import rf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [RF_SET_W-1:0]         shadowSelReq,
  input  logic                        quadMode,
  input  logic [RF_RD*RF_IDX_W-1:0]   rdIdx,
  input  logic [RF_RD-1:0]            rdWide,
  output logic [RF_RD*RF_DATA_W-1:0]  rdData,
  input  logic [RF_WR-1:0]            wrEn,
  input  logic [RF_WR*RF_IDX_W-1:0]   wrIdx,
  input  logic [RF_WR-1:0]            wrWide,
  input  logic [RF_WR*RF_DATA_W-1:0]  wrData,
  output logic [RF_SET_W-1:0]         activeSet
);
  rf_strobe_t strobe;

  rf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .setReq(shadowSelReq), .quadMode(quadMode),
    .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx), .wrWide(wrWide),
    .strobe(strobe), .activeSet(activeSet)
  );

  rf_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdWide(rdWide), .rdData(rdData)
  );
endmodule

// File: tb/tb_rf_banked_top.sv
module tb_rf_banked_top;
  import rf_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                        rstN;
  logic                        shadowSelReq;
  logic                        quadMode;
  logic [RF_RD*RF_IDX_W-1:0]   rdIdx;
  logic [RF_RD-1:0]            rdWide;
  logic [RF_RD*RF_DATA_W-1:0]  rdData;
  logic [RF_WR-1:0]            wrEn;
  logic [RF_WR*RF_IDX_W-1:0]   wrIdx;
  logic [RF_WR-1:0]            wrWide;
  logic [RF_WR*RF_DATA_W-1:0]  wrData;
  logic                        activeSet;

  rf_banked_top dut (.*);

  logic [RF_DATA_W-1:0] model [RF_PHYS];
  logic                 modelSet;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, logic [RF_DATA_W-1:0] act, logic [RF_DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RF_DATA_W-1:0] expRead(int r);
    logic [3:0] idx;
    logic [RF_DATA_W-1:0] w;
    idx = rdIdx[r*4 +: 4];
    if (quadMode && r < 4) idx = {r[1:0], idx[1:0]};
    w = model[{modelSet, idx}];
    return rdWide[r] ? w : {8'h00, w[39:8]};
  endfunction

  function automatic logic [RF_DATA_W-1:0] rdPort(int r);
    return rdData[r*RF_DATA_W +: RF_DATA_W];
  endfunction

  task automatic checkAllReads(string req);
    for (int r = 0; r < RF_RD; r++) check(req, rdPort(r), expRead(r));
  endtask

  task automatic clearInputs();
    quadMode = 0; rdIdx = '0; rdWide = '1;
    wrEn = '0; wrIdx = '0; wrWide = '0; wrData = '0;
  endtask

  task automatic setWr(int w, logic [3:0] idx, bit wide, logic [39:0] d);
    wrEn[w] = 1'b1; wrIdx[w*4 +: 4] = idx; wrWide[w] = wide;
    wrData[w*RF_DATA_W +: RF_DATA_W] = d;
  endtask

  task automatic setRd(int r, logic [3:0] idx, bit wide);
    rdIdx[r*4 +: 4] = idx; rdWide[r] = wide;
  endtask

  // one rising edge; model follows the spec with port 0 applied last
  task automatic step();
    @(posedge clk);
    for (int w = RF_WR - 1; w >= 0; w--) begin
      if (wrEn[w]) begin
        logic [39:0] d;
        d = wrData[w*RF_DATA_W +: RF_DATA_W];
        model[{modelSet, wrIdx[w*4 +: 4]}] = wrWide[w] ? d : {d[31:0], 8'h00};
      end
    end
    modelSet = shadowSelReq;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int p = 0; p < RF_PHYS; p++) model[p] = '0;
    modelSet = 0;
    rstN = 0; shadowSelReq = 0;
    clearInputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int r = 0; r < RF_RD; r++) setRd(r, 4'(r * 3), 1);
    #1;
    check("R1", 40'(activeSet), 40'd0);
    checkAllReads("R1");
    rstN = 1;
    @(negedge clk);

    // R2 write wide, R9 same-cycle read sees old
    setWr(2, 4'd3, 1, 40'hA5_1234_5678);
    setRd(0, 4'd3, 1);
    #1 check("R9", rdPort(0), 40'h0);
    step(); clearInputs();
    setRd(0, 4'd3, 1);
    #1 check("R2", rdPort(0), 40'hA5_1234_5678);

    // R3 narrow write ignores top data bits, R4 narrow read
    setWr(1, 4'd5, 0, 40'hFF_DEAD_BEEF);
    step(); clearInputs();
    setRd(0, 4'd5, 1); setRd(1, 4'd5, 0); setRd(2, 4'd3, 0);
    #1;
    check("R3", rdPort(0), 40'hDE_ADBE_EF00);
    check("R4", rdPort(1), 40'h00_DEAD_BEEF);
    check("R4", rdPort(2), 40'h00_A512_3456);

    // R8 conflict: lowest port wins
    setWr(4, 4'd7, 1, 40'h44_4444_4444);
    setWr(3, 4'd7, 1, 40'h33_3333_3333);
    setWr(1, 4'd7, 1, 40'h11_1111_1111);
    step(); clearInputs();
    setRd(3, 4'd7, 1);
    #1 check("R8", rdPort(3), 40'h11_1111_1111);

    // R11 disabled port leaves register alone
    wrIdx[0 +: 4] = 4'd8; wrWide[0] = 1; wrData[0 +: 40] = 40'h12_3456_789A;
    step(); clearInputs();
    setRd(4, 4'd8, 1);
    #1 check("R11", rdPort(4), 40'h0);

    // R6 switch takes effect only after the edge; R5 sets are separate
    shadowSelReq = 1;
    setRd(0, 4'd3, 1);
    #1;
    check("R6", 40'(activeSet), 40'd0);
    check("R6", rdPort(0), 40'hA5_1234_5678);
    step(); clearInputs();
    setRd(0, 4'd3, 1);
    #1;
    check("R6", 40'(activeSet), 40'd1);
    check("R5", rdPort(0), 40'h0);
    setWr(0, 4'd3, 1, 40'h5A_0F0F_0F0F);
    step(); clearInputs();
    shadowSelReq = 0;
    step(); clearInputs();
    setRd(0, 4'd3, 1);
    #1 check("R5", rdPort(0), 40'hA5_1234_5678);
    shadowSelReq = 1;
    step(); clearInputs();
    setRd(0, 4'd3, 1);
    #1 check("R5", rdPort(0), 40'h5A_0F0F_0F0F);
    shadowSelReq = 0;
    step(); clearInputs();

    // R10 quad mode, bank per port; port 4 unrestricted
    setWr(0, 4'd1, 1, 40'h01_0000_0001);
    setWr(1, 4'd6, 1, 40'h06_0000_0006);
    setWr(2, 4'd11, 1, 40'h0B_0000_000B);
    setWr(3, 4'd12, 1, 40'h0C_0000_000C);
    step(); clearInputs();
    quadMode = 1;
    setRd(0, 4'b1101, 1); setRd(1, 4'b0010, 1);
    setRd(2, 4'b0111, 1); setRd(3, 4'b1000, 1); setRd(4, 4'b1011, 1);
    #1;
    check("R10", rdPort(0), 40'h01_0000_0001);
    check("R10", rdPort(1), 40'h06_0000_0006);
    check("R10", rdPort(2), 40'h0B_0000_000B);
    check("R10", rdPort(3), 40'h0C_0000_000C);
    check("R10", rdPort(4), 40'h0B_0000_000B);
    step(); clearInputs();

    // R7 random traffic on all ports against the model
    for (int c = 0; c < 3000; c++) begin
      for (int w = 0; w < RF_WR; w++) begin
        wrEn[w] = ($urandom_range(0, 2) == 0);
        wrIdx[w*4 +: 4] = 4'($urandom_range(0, 15));
        wrWide[w] = 1'($urandom_range(0, 1));
        wrData[w*RF_DATA_W +: RF_DATA_W] = {8'($urandom()), 32'($urandom())};
      end
      for (int r = 0; r < RF_RD; r++) setRd(r, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
      quadMode = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) shadowSelReq = ~shadowSelReq;
      #1;
      checkAllReads("R7");
      check("R6", 40'(activeSet), 40'(modelSet));
      step();
    end
    finishRun();
  end
endmodule